// File: doc/BRIEF.md
# Register-Triggered Bus I/O Cycle Engine

This block lets a local processor run one single-word I/O read or write on an external bus through a few memory-mapped registers. Software loads a target address and, for a write, a data word. It then stores a control word. That store launches exactly one cycle on a simple request/acknowledge master handshake. The control word carries active-low byte enables and a direction bit.

When the far side acknowledges, the engine captures read data into its data register, drops its busy flag and raises a done flag. Software clears the done flag by writing 1 to it. An optional interrupt follows the done flag. The engine refuses to start while its own cycle or an external configuration cycle is in progress, and records each refused start in a sticky error flag.

Register byte offsets on `cpu_addr`: 0x00 target address, 0x04 data, 0x08 control, 0x0C status, 0x10 interrupt enable. Reads are combinational from `cpu_addr`.

Top module: `bio_cycle_engine`

## Requirements
- R1: A write to the control register (offset 0x08) while status busy and `cfg_busy` are both low sets status bit 0 (busy) and asserts `bus_req` from the next clock edge. `bus_req` stays high until the cycle in which `bus_ack` is sampled, and each accepted store yields exactly one bus cycle.
- R2: While `bus_req` is high, `bus_be_n` equals control bits [3:0] unchanged, active low, with bit n gating data bits [8n+7:8n]. While idle, `bus_be_n` is all ones.
- R3: `bus_rd` equals control bit 4 of the launching store: 1 selects a read and 0 selects a write.
- R4: On a read, `bus_addr` carries the address register value, and the word on `bus_rdata` at the acknowledge edge becomes the data register value (offset 0x04).
- R5: On a write, `bus_wdata` carries the data register value, and the data register is unchanged after completion.
- R6: At the edge where `bus_ack` is sampled with `bus_req` high, busy clears and status bit 1 (done) sets together.
- R7: Writing status with bit 1 set clears done, and writing 0 there leaves done unchanged. If a hardware set and a clear fall in the same cycle, the set wins.
- R8: `irq` is high exactly while done is set and bit 0 of the interrupt-enable register (offset 0x10) is 1.
- R9: A control store made while busy or `cfg_busy` is high starts no cycle and sets sticky status bit 2 (error). Writing 1 to bit 2 clears it. Status bit 3 mirrors `cfg_busy`.
- R10: The address and data registers accept writes and read back new values while busy, but `bus_addr` and `bus_wdata` of the cycle in flight do not change.
- R11: After reset all registers read 0, `bus_req` and `irq` are low and `bus_be_n` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | Register write strobe |
| cpu_addr | input | 5 | Register byte offset |
| cpu_wdata | input | DATA_W | Register write data |
| cpu_rdata | output | DATA_W | Register read data for `cpu_addr` |
| cfg_busy | input | 1 | A configuration cycle is running elsewhere |
| bus_req | output | 1 | Cycle request, held until acknowledge |
| bus_rd | output | 1 | 1 read, 0 write |
| bus_addr | output | ADDR_W | Cycle address |
| bus_be_n | output | DATA_W/8 | Active-low byte enables |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Returned read data |
| bus_ack | input | 1 | Cycle completion from the far side |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench launches writes and reads with several byte-enable patterns: all lanes, the two low lanes, and alternating lanes. It uses responder latencies of zero, several and many cycles. The mix separates a lane or polarity swap, a wrong direction bit, and a capture that fires on writes or on the wrong edge. Refused starts are tried both under the engine's own busy flag and under `cfg_busy`. Address and data are rewritten during a long cycle to tell a live register path from a launch-time copy. Done and error are written with 0 and then 1 to separate write-one-to-clear from plain writes, and the interrupt is checked with its enable both off and on.

// File: rtl/bio_pkg.sv
package bio_pkg;
   localparam int unsigned REG_AW = 5;

   typedef enum logic [2:0] {
      IDX_ADDR = 3'd0,
      IDX_DATA = 3'd1,
      IDX_CTRL = 3'd2,
      IDX_STAT = 3'd3,
      IDX_IEN  = 3'd4
   } reg_idx_e;

   localparam int unsigned ST_BUSY = 0;
   localparam int unsigned ST_DONE = 1;
   localparam int unsigned ST_ERR  = 2;
   localparam int unsigned ST_CFG  = 3;
endpackage

// File: rtl/bio_lane_cap.sv
module bio_lane_cap #(
   parameter int unsigned DATA_W          = 32,
   parameter bit          MASK_IDLE_LANES = 1'b0,
   localparam int unsigned LANES          = DATA_W / 8
) (
   input  logic [DATA_W-1:0] old_word,
   input  logic [DATA_W-1:0] new_word,
   input  logic [LANES-1:0]  be_n,
   output logic [DATA_W-1:0] merged
);
   wire unused_lane_in = ^{old_word, be_n};

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      if (MASK_IDLE_LANES) begin : g_mask
         assign merged[8*i +: 8] = be_n[i] ? old_word[8*i +: 8] : new_word[8*i +: 8];
      end else begin : g_full
         assign merged[8*i +: 8] = new_word[8*i +: 8];
      end
   end
endmodule

// File: rtl/bio_regs.sv
module bio_regs
   import bio_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  reg_idx_e          idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] cap_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q,
   output logic              ien_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
         ien_q  <= 1'b0;
      end else begin
         if (wr_en && idx == IDX_ADDR) addr_q <= wdata[ADDR_W-1:0];
         if (cap_en)                        data_q <= cap_data;
         else if (wr_en && idx == IDX_DATA) data_q <= wdata;
         if (wr_en && idx == IDX_IEN)  ien_q <= wdata[0];
      end
   end

   assert_data_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!cap_en && !(wr_en && idx == IDX_DATA)) |=> $stable(data_q));
endmodule

// File: rtl/bio_seq.sv
module bio_seq #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32,
   localparam int unsigned LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_wr,
   input  logic [LANES:0]    ctrl_in,
   input  logic              clr_done,
   input  logic              clr_err,
   input  logic              cfg_busy,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic              bus_ack,
   output logic              busy_q,
   output logic              done_q,
   output logic              err_q,
   output logic [LANES:0]    ctrl_q,
   output logic              bus_req,
   output logic              bus_rd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [LANES-1:0]  bus_be_n,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              cap_en
);
   logic              accept, reject, finish;
   logic [ADDR_W-1:0] addr_snap;
   logic [DATA_W-1:0] data_snap;

   assign accept = start_wr && !busy_q && !cfg_busy;
   assign reject = start_wr && (busy_q || cfg_busy);
   assign finish = busy_q && bus_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         ctrl_q    <= '0;
         addr_snap <= '0;
         data_snap <= '0;
      end else begin
         if (accept) begin
            busy_q    <= 1'b1;
            ctrl_q    <= ctrl_in;
            addr_snap <= addr_in;
            data_snap <= data_in;
         end else if (finish) begin
            busy_q <= 1'b0;
         end
         done_q <= finish || (done_q && !clr_done);
         err_q  <= reject || (err_q && !clr_err);
      end
   end

   assign bus_req   = busy_q;
   assign bus_rd    = ctrl_q[LANES];
   assign bus_be_n  = busy_q ? ctrl_q[LANES-1:0] : '1;
   assign bus_addr  = addr_snap;
   assign bus_wdata = data_snap;
   assign cap_en    = finish && ctrl_q[LANES];

   assert_launch_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && !bus_req && !cfg_busy) |=> bus_req);
   assert_hold_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> bus_req);
   assert_be_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && $past(bus_req)) |-> ($stable(bus_be_n) && $stable(bus_rd)));
   assert_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> (!bus_req && done_q));
   assert_done_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !clr_done) |=> done_q);
   assert_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_wr && (bus_req || cfg_busy)) |=> err_q);
   assert_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && $past(bus_req)) |-> ($stable(bus_addr) && $stable(bus_wdata)));
endmodule

// File: rtl/bio_cycle_engine.sv
module bio_cycle_engine
   import bio_pkg::*;
#(
   parameter int unsigned DATA_W          = 32,
   parameter int unsigned ADDR_W          = 32,
   parameter bit          MASK_IDLE_LANES = 1'b0,
   localparam int unsigned LANES          = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr,
   input  logic [REG_AW-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              cfg_busy,
   output logic              bus_req,
   output logic              bus_rd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [LANES-1:0]  bus_be_n,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_ack,
   output logic              irq
);
   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
      $error("DATA_W must be a multiple of 8 and at least 16");
   end
   if (ADDR_W < 1 || ADDR_W > DATA_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 1 and DATA_W");
   end

   reg_idx_e          idx;
   logic              start_wr, clr_done, clr_err, ien_wr;
   logic              busy_q, done_q, err_q, ien_q, cap_en;
   logic [LANES:0]    ctrl_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q, cap_word;
   wire               unused_lo_addr = ^cpu_addr[1:0];

   assign idx      = reg_idx_e'(cpu_addr[REG_AW-1:2]);
   assign start_wr = cpu_wr && idx == IDX_CTRL;
   assign clr_done = cpu_wr && idx == IDX_STAT && cpu_wdata[ST_DONE];
   assign clr_err  = cpu_wr && idx == IDX_STAT && cpu_wdata[ST_ERR];
   assign ien_wr   = cpu_wr && idx == IDX_IEN;

   bio_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .idx(idx), .wdata(cpu_wdata),
      .cap_en(cap_en), .cap_data(cap_word),
      .addr_q(addr_q), .data_q(data_q), .ien_q(ien_q)
   );

   bio_lane_cap #(.DATA_W(DATA_W), .MASK_IDLE_LANES(MASK_IDLE_LANES)) u_cap (
      .old_word(data_q), .new_word(bus_rdata), .be_n(bus_be_n), .merged(cap_word)
   );

   bio_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_wr(start_wr),
      .ctrl_in(cpu_wdata[LANES:0]), .clr_done(clr_done), .clr_err(clr_err),
      .cfg_busy(cfg_busy), .addr_in(addr_q), .data_in(data_q), .bus_ack(bus_ack),
      .busy_q(busy_q), .done_q(done_q), .err_q(err_q), .ctrl_q(ctrl_q),
      .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_be_n(bus_be_n), .bus_wdata(bus_wdata), .cap_en(cap_en)
   );

   always_comb begin
      cpu_rdata = '0;
      case (idx)
         IDX_ADDR: cpu_rdata = DATA_W'(addr_q);
         IDX_DATA: cpu_rdata = data_q;
         IDX_CTRL: cpu_rdata = DATA_W'(ctrl_q);
         IDX_STAT: cpu_rdata = DATA_W'({cfg_busy, err_q, done_q, busy_q});
         IDX_IEN:  cpu_rdata = DATA_W'(ien_q);
         default:  cpu_rdata = '0;
      endcase
   end

   assign irq = done_q && ien_q;

   assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && ien_q && !clr_done && !ien_wr) |=> irq);
   assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!done_q && !bus_req) |=> !irq);
endmodule

// File: tb/tb_bio_cycle_engine.sv
module tb_bio_cycle_engine;
   localparam int DW = 32;
   localparam int AW = 32;

   typedef struct {
      logic        rd;
      logic [31:0] addr;
      logic [3:0]  ben;
      logic [31:0] wdata;
      logic [31:0] rdata;
   } item_t;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [4:0]    cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
   logic          cfg_busy = 1'b0;
   logic          bus_req, bus_rd, bus_ack = 1'b0, irq;
   logic [AW-1:0] bus_addr;
   logic [3:0]    bus_be_n;
   logic [DW-1:0] bus_wdata, bus_rdata = '0;

   int    n_cmp = 0, n_bad = 0, lat = 2;
   item_t exp_q[$];

   always #2 clk = ~clk;

   bio_cycle_engine dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cfg_busy(cfg_busy),
      .bus_req(bus_req), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_be_n(bus_be_n),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
      @(negedge clk);
      cpu_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      cpu_addr = a;
      #1 d = cpu_rdata;
   endtask

   task automatic launch(input logic r, input logic [3:0] ben, input logic [31:0] a,
                         input logic [31:0] wd, input logic [31:0] rdv);
      item_t it;
      it.rd = r; it.addr = a; it.ben = ben; it.wdata = wd; it.rdata = rdv;
      exp_q.push_back(it);
      wr(5'h00, a);
      if (!r) wr(5'h04, wd);
      wr(5'h08, {27'd0, r, ben});
   endtask

   task automatic wait_done(input string req);
      logic [31:0] s;
      for (int i = 0; i < 60; i++) begin
         rd(5'h0C, s);
         if (s[1]) return;
         @(negedge clk);
      end
      chk(req, 32'd0, 32'd2);
   endtask

   // monitor / responder: pops expected items and compares each bus cycle
   initial begin
      forever begin
         @(negedge clk);
         if (bus_req) begin
            item_t it;
            if (exp_q.size() == 0) begin
               chk("R1 unexpected cycle", 32'd1, 32'd0);
            end else begin
               it = exp_q.pop_front();
               chk("R3 direction", {31'd0, bus_rd}, {31'd0, it.rd});
               chk("R2 byte enables", {28'd0, bus_be_n}, {28'd0, it.ben});
               chk("R4 address", bus_addr, it.addr);
               if (!it.rd) chk("R5 write data", bus_wdata, it.wdata);
               repeat (lat) @(negedge clk);
               chk("R10 address held", bus_addr, it.addr);
               if (!it.rd) chk("R10 write data held", bus_wdata, it.wdata);
               chk("R1 request held", {31'd0, bus_req}, 32'd1);
               bus_rdata = it.rdata;
               bus_ack   = 1'b1;
               @(negedge clk);
               bus_ack   = 1'b0;
               bus_rdata = '0;
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      for (int a = 0; a < 5; a++) begin
         rd(5'(a * 4), v);
         chk("R11 register reset", v, 32'd0);
      end
      chk("R11 bus_req idle", {31'd0, bus_req}, 32'd0);
      chk("R11 be idle", {28'd0, bus_be_n}, 32'hF);
      chk("R11 irq idle", {31'd0, irq}, 32'd0);

      // R1/R5/R6: full-lane write
      lat = 2;
      launch(1'b0, 4'b0000, 32'h0000_1230, 32'hA5A5_0F0F, 32'h0);
      rd(5'h0C, v);
      chk("R1 busy after start", v & 32'h3, 32'h1);
      chk("R1 request after start", {31'd0, bus_req}, 32'd1);
      wait_done("R6 done");
      rd(5'h0C, v);
      chk("R6 busy clear with done", v & 32'h3, 32'h2);
      chk("R2 be idle after cycle", {28'd0, bus_be_n}, 32'hF);
      rd(5'h04, v);
      chk("R5 data unchanged", v, 32'hA5A5_0F0F);
      chk("R8 no irq when disabled", {31'd0, irq}, 32'd0);

      // R7: W1C
      wr(5'h0C, 32'h0);
      rd(5'h0C, v);
      chk("R7 write 0 keeps done", v & 32'h2, 32'h2);
      wr(5'h0C, 32'h2);
      rd(5'h0C, v);
      chk("R7 write 1 clears done", v & 32'h2, 32'h0);

      // R4: read on two low lanes, latency 3
      lat = 3;
      launch(1'b1, 4'b1100, 32'h0000_0040, 32'h0, 32'hDEAD_BEEF);
      wait_done("R4 done");
      rd(5'h04, v);
      chk("R4 captured word", v, 32'hDEAD_BEEF);
      rd(5'h08, v);
      chk("R3 control readback", v, 32'h1C);
      wr(5'h0C, 32'h2);

      // R8: interrupt, zero latency read
      wr(5'h10, 32'h1);
      lat = 0;
      launch(1'b1, 4'b0101, 32'h0000_0088, 32'h0, 32'h1357_9BDF);
      wait_done("R8 done");
      @(negedge clk);
      chk("R8 irq with done", {31'd0, irq}, 32'd1);
      wr(5'h0C, 32'h2);
      chk("R8 irq drops on clear", {31'd0, irq}, 32'd0);
      wr(5'h10, 32'h0);

      // R9/R10: refused start while busy, register writes in flight
      lat = 8;
      launch(1'b0, 4'b1010, 32'h0000_0200, 32'h0BAD_F00D, 32'h0);
      wr(5'h08, 32'h10);
      rd(5'h0C, v);
      chk("R9 error on busy start", v & 32'h5, 32'h5);
      wr(5'h00, 32'h0000_FFFF);
      wr(5'h04, 32'h0000_1234);
      rd(5'h00, v);
      chk("R10 address readback", v, 32'h0000_FFFF);
      wait_done("R9 done");
      repeat (4) @(negedge clk);
      chk("R9 no second cycle", {31'd0, bus_req}, 32'd0);
      rd(5'h04, v);
      chk("R10 data readback", v, 32'h0000_1234);
      wr(5'h0C, 32'h6);
      rd(5'h0C, v);
      chk("R9 error cleared", v, 32'h0);

      // R9: refused under configuration busy
      cfg_busy = 1'b1;
      wr(5'h08, 32'h0);
      rd(5'h0C, v);
      chk("R9 cfg mirror and error", v, 32'hC);
      chk("R9 no cycle under cfg", {31'd0, bus_req}, 32'd0);
      cfg_busy = 1'b0;
      wr(5'h0C, 32'h4);
      rd(5'h0C, v);
      chk("R9 error clear", v, 32'h0);

      chk("R1 all cycles seen", exp_q.size(), 32'd0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule